// File: doc/BRIEF.md
# Module ID Memory SPI Read Responder

This block acts as an SPI target that answers short read transactions on behalf of two plug-in module identification memories. Each module has its own 256-byte ID store and a present flag. A host picks the module by writing a select byte elsewhere in the chip; that byte reaches this block as a plain input. The host then runs a four-byte SPI transaction. Its request is a read command, an offset, and two padding bytes. The block shifts back a reply of the same length.

For a selected, present module the reply starts with two zero bytes. The stored byte at the requested offset follows, then the byte after it. When no module is selected, or the chosen one is absent, every reply bit is 1. The SPI pins are sampled by the block's own clock through a synchronizer, so SCK must run several times slower than `clk`. The ID stores are filled through a valid/ready write port. That port applies back-pressure for the whole time chip select is low, which keeps a load from racing a read.

Top module: `spi_id_responder`

## Requirements
- R1: After reset `spi_miso` is 1 and `ld_ready` is 1.
- R2: For a valid frame (selected module present), reply bytes 0 and 1 are 0x00.
- R3: For a valid frame, reply byte 2 is the selected store's byte at the offset received as request byte 1. Reply byte 3 is the byte at offset+1.
- R4: Offset+1 wraps inside the 8-bit space, so offset 0xFF returns the bytes at 0xFF and then at 0x00.
- R5: If `sel_byte` bit 5 is 1, module 0 is chosen, whatever the value of bit 3.
- R6: If bit 5 is 0 and bit 3 is 1, module 1 is chosen.
- R7: If `sel_byte` bits 5 and 3 are both 0, every reply byte is 0xFF.
- R8: If the chosen module's `mod_present` bit (bit 0 for module 0, bit 1 for module 1) is 0, every reply byte is 0xFF.
- R9: Select and present are taken when chip select falls. Changing them during the frame does not alter that frame's reply.
- R10: SPI mode 0, MSB first. The first reply bit is valid before the first rising SCK edge. MOSI is sampled on rising edges. MISO changes only after falling edges.
- R11: Raising chip select ends the frame. The next frame starts again at reply byte 0, whatever number of bits came before. `spi_miso` is 1 while chip select is high.
- R12: `ld_ready` is 0 while a frame is in progress. A write to the ID store takes effect only on a cycle with both `ld_valid` and `ld_ready` high.
- R13: Reply bytes after the fourth are 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; SPI pins are oversampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI clock from host, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Request data from host |
| spi_miso | output | 1 | Reply data to host |
| sel_byte | input | 8 | Module select byte (bit 5 module 0, bit 3 module 1) |
| mod_present | input | 2 | Per-module ID memory present flags |
| ld_valid | input | 1 | ID store write request |
| ld_ready | output | 1 | ID store can take a write (idle only) |
| ld_mod | input | 1 | Target module of the write |
| ld_addr | input | 8 | Byte address of the write |
| ld_data | input | 8 | Byte written |

## Verification
The bench builds the block with its defaults: 8-bit addresses (256-byte stores), a two-stage synchronizer, and select bits 5 and 3. With the full depth, the offset-wrap case at 0xFF can be reached. With the real select positions, the priority and no-select cases can be driven with realistic select bytes. The SCK half period is eight block clocks. That covers the synchronizer and edge-detect latency, so MISO can be compared with the reference model on every clock of each SCK high phase.

// File: rtl/spi_id_pkg.sv
package spi_id_pkg;
  localparam int BYTE_W   = 8;
  localparam int NUM_MOD  = 2;
  localparam int MOD_W    = 1;
  localparam int FRAME_LEN = 4;
  localparam int BCNT_W   = 3;
  localparam logic [BYTE_W-1:0] FILL_BYTE = 8'hFF;
  localparam logic [BYTE_W-1:0] PAD_BYTE  = 8'h00;

  typedef struct packed {
    logic             hit;
    logic [MOD_W-1:0] idx;
  } mod_pick_t;
endpackage

// File: rtl/spi_id_sync_edge.sv
module spi_id_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_in,
  input  logic cs_n_in,
  input  logic mosi_in,
  output logic mosi_s,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_start,
  output logic cs_end,
  output logic cs_active
);
  logic [STAGES-1:0] sck_c, cs_c, mosi_c;
  logic sck_q, act_s;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sck_c <= '0; cs_c <= '1; mosi_c <= '0;
        end else begin
          sck_c <= sck_in; cs_c <= cs_n_in; mosi_c <= mosi_in;
        end
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sck_c <= '0; cs_c <= '1; mosi_c <= '0;
        end else begin
          sck_c  <= {sck_c[STAGES-2:0], sck_in};
          cs_c   <= {cs_c[STAGES-2:0], cs_n_in};
          mosi_c <= {mosi_c[STAGES-2:0], mosi_in};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q     <= 1'b0;
      cs_active <= 1'b0;
    end else begin
      sck_q     <= sck_c[STAGES-1];
      cs_active <= act_s;
    end
  end

  assign act_s    = ~cs_c[STAGES-1];
  assign mosi_s   = mosi_c[STAGES-1];
  assign sck_rise = sck_c[STAGES-1] & ~sck_q;
  assign sck_fall = ~sck_c[STAGES-1] & sck_q;
  assign cs_start = act_s & ~cs_active;
  assign cs_end   = ~act_s & cs_active;
endmodule

// File: rtl/spi_id_store.sv
module spi_id_store
  import spi_id_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [MOD_W-1:0]  wr_mod,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [MOD_W-1:0]  rd_mod,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [NUM_MOD-1:0][BYTE_W-1:0] bank_q;

  generate
    for (genvar g = 0; g < NUM_MOD; g++) begin : g_bank
      logic [BYTE_W-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
        if (wr_en && wr_mod == MOD_W'(g)) mem[wr_addr] <= wr_data;
      end
      assign bank_q[g] = mem[rd_addr];
    end
  endgenerate

  assign rd_data = bank_q[rd_mod];
endmodule

// File: rtl/spi_id_shifter.sv
module spi_id_shifter
  import spi_id_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mosi_s,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              cs_start,
  input  logic              cs_end,
  input  logic              ok_in,
  input  logic [MOD_W-1:0]  mod_in,
  input  logic [BYTE_W-1:0] mem_byte,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [MOD_W-1:0]  mod_q,
  output logic              frame_ok,
  output logic [2:0]        bit_cnt,
  output logic [BCNT_W-1:0] byte_cnt,
  output logic [ADDR_W-1:0] offset,
  output logic              miso
);
  logic [BYTE_W-1:0] rx_q, tx_q, next_byte;
  logic [BYTE_W-1:0] rx_full;

  assign rx_full = {rx_q[BYTE_W-2:0], mosi_s};
  assign rd_addr = (byte_cnt == BCNT_W'(3)) ? offset + ADDR_W'(1) : offset;

  always_comb begin
    case (byte_cnt)
      BCNT_W'(1):            next_byte = frame_ok ? PAD_BYTE : FILL_BYTE;
      BCNT_W'(2), BCNT_W'(3): next_byte = frame_ok ? mem_byte : FILL_BYTE;
      default:               next_byte = FILL_BYTE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q     <= '0;
      tx_q     <= FILL_BYTE;
      bit_cnt  <= '0;
      byte_cnt <= '0;
      offset   <= '0;
      frame_ok <= 1'b0;
      mod_q    <= '0;
    end else if (cs_start) begin
      bit_cnt  <= '0;
      byte_cnt <= '0;
      frame_ok <= ok_in;
      mod_q    <= mod_in;
      tx_q     <= ok_in ? PAD_BYTE : FILL_BYTE;
    end else if (cs_end) begin
      bit_cnt  <= '0;
      byte_cnt <= '0;
      tx_q     <= FILL_BYTE;
    end else begin
      if (sck_rise) begin
        rx_q    <= rx_full;
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          if (byte_cnt < BCNT_W'(FRAME_LEN)) byte_cnt <= byte_cnt + BCNT_W'(1);
          if (byte_cnt == BCNT_W'(1)) offset <= rx_full[ADDR_W-1:0];
        end
      end
      if (sck_fall) begin
        if (bit_cnt == 3'd0 && byte_cnt != '0) tx_q <= next_byte;
        else tx_q <= {tx_q[BYTE_W-2:0], 1'b1};
      end
    end
  end

  assign miso = tx_q[BYTE_W-1];
endmodule

// File: rtl/spi_id_responder.sv
module spi_id_responder
  import spi_id_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int SEL0_BIT    = 5,
  parameter int SEL1_BIT    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic [7:0]        sel_byte,
  input  logic [1:0]        mod_present,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [MOD_W-1:0]  ld_mod,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [BYTE_W-1:0] ld_data
);
  logic mosi_s, sck_rise, sck_fall, cs_start, cs_end, cs_active;
  logic frame_ok, ok_in;
  mod_pick_t pick;
  logic [MOD_W-1:0]  mod_q;
  logic [ADDR_W-1:0] rd_addr, offset;
  logic [BYTE_W-1:0] mem_byte;
  logic [2:0]        bit_cnt;
  logic [BCNT_W-1:0] byte_cnt;

  always_comb begin
    pick.hit = 1'b1;
    pick.idx = '0;
    if (sel_byte[SEL0_BIT])      pick.idx = MOD_W'(0);
    else if (sel_byte[SEL1_BIT]) pick.idx = MOD_W'(1);
    else                         pick.hit = 1'b0;
  end
  assign ok_in    = pick.hit & mod_present[pick.idx];
  assign ld_ready = ~cs_active;

  spi_id_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck_in(spi_sck), .cs_n_in(spi_cs_n),
    .mosi_in(spi_mosi), .mosi_s(mosi_s), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .cs_start(cs_start), .cs_end(cs_end),
    .cs_active(cs_active)
  );

  spi_id_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .wr_en(ld_valid & ld_ready), .wr_mod(ld_mod),
    .wr_addr(ld_addr), .wr_data(ld_data), .rd_mod(mod_q),
    .rd_addr(rd_addr), .rd_data(mem_byte)
  );

  spi_id_shifter #(.ADDR_W(ADDR_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .mosi_s(mosi_s), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .cs_start(cs_start), .cs_end(cs_end),
    .ok_in(ok_in), .mod_in(pick.idx), .mem_byte(mem_byte),
    .rd_addr(rd_addr), .mod_q(mod_q), .frame_ok(frame_ok),
    .bit_cnt(bit_cnt), .byte_cnt(byte_cnt), .offset(offset),
    .miso(spi_miso)
  );
endmodule

// File: rtl/spi_id_responder_chk.sv
module spi_id_responder_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              miso,
  input logic              sck_rise,
  input logic              sck_fall,
  input logic              cs_start,
  input logic              cs_end,
  input logic              cs_active,
  input logic              frame_ok,
  input logic [2:0]        bit_cnt,
  input logic [2:0]        byte_cnt,
  input logic [ADDR_W-1:0] offset
);
  AST_MISO_ONLY_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck_fall && !cs_start && !cs_end) |=> $stable(miso)); // R10
  AST_IDLE_MISO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |-> miso); // R11
  AST_COUNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    cs_start |=> (bit_cnt == 3'd0 && byte_cnt == 3'd0)); // R11
  AST_FILL_WHEN_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_active && !frame_ok) |-> miso); // R7
  AST_OFFSET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_cnt >= 3'd2 && !cs_start) |=> $stable(offset)); // R3
  AST_BYTE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_rise && bit_cnt == 3'd7 && byte_cnt < 3'd4 && !cs_start && !cs_end)
      |=> byte_cnt == $past(byte_cnt) + 3'd1); // R10
endmodule

bind spi_id_responder spi_id_responder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .miso(spi_miso), .sck_rise(sck_rise),
  .sck_fall(sck_fall), .cs_start(cs_start), .cs_end(cs_end),
  .cs_active(cs_active), .frame_ok(frame_ok), .bit_cnt(bit_cnt),
  .byte_cnt(byte_cnt), .offset(offset)
);

// File: tb/tb_spi_id_responder.sv
module tb_spi_id_responder;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso;
  logic [7:0] sel_byte = 8'h00;
  logic [1:0] mod_present = 2'b00;
  logic ld_valid = 1'b0, ld_ready;
  logic ld_mod = 1'b0;
  logic [7:0] ld_addr = 8'h00, ld_data = 8'h00;

  int errors = 0;
  int checks = 0;
  logic chk_en = 1'b0;
  logic exp_bit = 1'b1;
  int   ref_mem [2][256];

  always #2 clk = ~clk;

  spi_id_responder dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .sel_byte(sel_byte),
    .mod_present(mod_present), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_mod(ld_mod), .ld_addr(ld_addr), .ld_data(ld_data)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison of MISO during each SCK high phase (R10)
  always @(negedge clk) begin
    if (chk_en) check("R10 miso bit", int'(spi_miso), int'(exp_bit));
  end

  function automatic int pat(input int m, input int a);
    return (m == 0) ? ((a * 37 + 11) & 255) : (((a * 91) ^ 8'h5C) & 255);
  endfunction

  task automatic xfer(input logic [7:0] sel, input logic [1:0] pres,
                      input logic [7:0] off, input int nbits,
                      input logic [7:0] sel2, input logic [1:0] pres2,
                      input string tag);
    logic [7:0] req [8];
    logic [7:0] expb [8];
    logic [7:0] got;
    int m;
    bit ok;
    m  = sel[5] ? 0 : 1;
    ok = sel[5] ? pres[0] : (sel[3] ? pres[1] : 1'b0);
    for (int i = 0; i < 8; i++) begin
      req[i]  = (i == 0) ? 8'h03 : ((i == 1) ? off : 8'h00);
      expb[i] = 8'hFF;
    end
    if (ok) begin
      expb[0] = 8'h00; expb[1] = 8'h00;
      expb[2] = 8'(ref_mem[m][off]);
      expb[3] = 8'(ref_mem[m][(int'(off) + 1) & 255]);
    end
    @(negedge clk);
    sel_byte = sel; mod_present = pres; spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    got = 8'h00;
    for (int k = 0; k < nbits; k++) begin
      int i = k / 8;
      int b = 7 - (k % 8);
      if (k == 8) begin sel_byte = sel2; mod_present = pres2; end
      spi_mosi = req[i][b];
      repeat (HALF) @(negedge clk);
      got[b] = spi_miso;
      exp_bit = expb[i][b];
      spi_sck = 1'b1;
      chk_en = 1'b1;
      if (k == 4) check("R12 ready low in frame", int'(ld_ready), 0);
      repeat (HALF) @(negedge clk);
      chk_en = 1'b0;
      spi_sck = 1'b0;
      if (b == 0) begin
        if (i >= 4)      check("R13 trailing byte", int'(got), int'(expb[i]));
        else if (ok && i < 2) check("R2 pad byte", int'(got), int'(expb[i]));
        else             check(tag, int'(got), int'(expb[i]));
      end
    end
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 miso after reset", int'(spi_miso), 1);
    check("R1 ready after reset", int'(ld_ready), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 miso idle", int'(spi_miso), 1);

    // fill both stores through the load port (R12)
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < 256; a++) begin
        ref_mem[m][a] = pat(m, a);
        ld_valid = 1'b1; ld_mod = 1'(m); ld_addr = 8'(a); ld_data = 8'(pat(m, a));
        @(negedge clk);
      end
    end
    ld_valid = 1'b0;

    xfer(8'h20, 2'b01, 8'h10, 32, 8'h20, 2'b01, "R3 module0 read");
    xfer(8'h20, 2'b11, 8'h7E, 32, 8'h20, 2'b11, "R3 second offset");
    xfer(8'h20, 2'b01, 8'hFF, 32, 8'h20, 2'b01, "R4 offset wrap");
    xfer(8'h28, 2'b01, 8'h33, 32, 8'h28, 2'b01, "R5 bit5 priority");
    xfer(8'h08, 2'b10, 8'h44, 32, 8'h08, 2'b10, "R6 module1 read");
    xfer(8'h08, 2'b11, 8'hFF, 32, 8'h08, 2'b11, "R6 module1 wrap");
    xfer(8'h00, 2'b11, 8'h10, 32, 8'h00, 2'b11, "R7 no select");
    xfer(8'hD7, 2'b11, 8'h10, 32, 8'hD7, 2'b11, "R7 other bits only");
    xfer(8'h20, 2'b10, 8'h10, 32, 8'h20, 2'b10, "R8 module0 absent");
    xfer(8'h28, 2'b10, 8'h10, 32, 8'h28, 2'b10, "R8 priority to absent");
    xfer(8'h08, 2'b01, 8'h10, 32, 8'h08, 2'b01, "R8 module1 absent");
    xfer(8'h20, 2'b01, 8'h55, 32, 8'h00, 2'b00, "R9 mid-frame select change");
    xfer(8'h08, 2'b10, 8'h66, 32, 8'h20, 2'b01, "R9 mid-frame switch module");
    xfer(8'h20, 2'b01, 8'h20, 48, 8'h20, 2'b01, "R13 long frame");

    // aborted frame after 13 bits, then a full frame (R11)
    xfer(8'h20, 2'b01, 8'hA0, 13, 8'h20, 2'b01, "R11 aborted frame");
    check("R11 miso high after abort", int'(spi_miso), 1);
    xfer(8'h08, 2'b10, 8'h05, 32, 8'h08, 2'b10, "R11 frame after abort");

    // write attempt while busy must be ignored (R12)
    fork
      xfer(8'h20, 2'b01, 8'h90, 32, 8'h20, 2'b01, "R12 frame during blocked write");
      begin
        repeat (100) @(negedge clk);
        ld_valid = 1'b1; ld_mod = 1'b0; ld_addr = 8'h40; ld_data = 8'h00;
        repeat (20) @(negedge clk);
        ld_valid = 1'b0;
      end
    join
    xfer(8'h20, 2'b01, 8'h40, 32, 8'h20, 2'b01, "R12 blocked write ignored");

    // accepted write while idle changes the reply (R12)
    @(negedge clk);
    ld_valid = 1'b1; ld_mod = 1'b1; ld_addr = 8'h81; ld_data = 8'hC3;
    check("R12 ready idle", int'(ld_ready), 1);
    @(negedge clk);
    ld_valid = 1'b0;
    ref_mem[1][8'h81] = 8'hC3;
    xfer(8'h08, 2'b10, 8'h80, 32, 8'h08, 2'b10, "R12 idle write seen");

    finish_run();
  end
endmodule